// File: doc/BRIEF.md
# Video Clock Divider with Tap Selection

This block is the programmable post-divider of a pixel clock tree, modelled entirely as clock-enable generation on one fast input clock so that no derived clocks appear in the design. A main counter divides the fast clock by a programmable value N. From its pulses, five fixed secondary taps at /1, /2, /4, /6 and /12 of the main rate are derived, each with its own gate. All taps count main-divider pulses, so every tap pulse coincides with a main pulse and the taps keep a fixed phase to one another.

Three consumers, a progressive encoder, an interlaced encoder and a transmitter pixel port, each pick one tap through a 4-bit select code and have their own output gate. One extra select code routes the /1 pulse of a neighbouring (alternate) divider channel to the consumer instead. A master channel enable gates all tap outputs, and the divider can be held or restarted through an enable, a held reset and a pulsed soft reset. Every output is a single-cycle enable on the fast clock.

Top module: `vclk_tap_divider`

## Requirements
- R1: The main divider produces one pulse every N fast-clock cycles, where `div_val` holds N-1 (0 to 255); `div_val`=0 gives a pulse every cycle and `div_val`=54 gives one every 55 cycles.
- R2: The divider runs only while `div_en` is 1 and `div_rst` is 0; otherwise no pulse is produced and the chain is held at its start, so the first main pulse comes N cycles after the release.
- R3: Tap k (k=0..4) pulses on every 1st, 2nd, 4th, 6th and 12th main pulse respectively, counted from the start of the chain; `tap_ce[k]` shows tap k only while `tap_gate[k]` and `chan_en` are both 1, and is a single-cycle pulse for k>=1.
- R4: A consumer with select code 0, 1, 2, 3 or 4 follows tap /1, /2, /4, /6 or /12; its output pulses one clock after the selected `tap_ce` pulse.
- R5: Select code 8 routes `alt_tick` (the alternate channel's /1 pulse) to the consumer, registered one clock.
- R6: A consumer whose select code is reserved (5, 6, 7, 9 to 15) or whose selected tap is gated off never pulses.
- R7: `cons_gate` bit 0, 1, 2 gates `prog_ce`, `intl_ce`, `tx_ce`; a cleared bit, or a cleared `chan_en` for tap selections, keeps that output low.
- R8: A new `div_val` takes effect at the next main terminal count: the period in progress finishes with the old value.
- R9: A soft reset held high for one or more cycles suppresses all pulses and restarts the chain from its start when released, with the first main pulse N cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 8 | Main divide value minus one |
| div_en | input | 1 | Main divider enable |
| div_rst | input | 1 | Main divider held reset |
| soft_rst | input | 1 | Channel soft reset, pulsed to restart the chain |
| chan_en | input | 1 | Master channel enable for all taps |
| tap_gate | input | 5 | Per-tap gate, bit k for tap /1,/2,/4,/6,/12 |
| sel_prog | input | 4 | Progressive encoder select code |
| sel_intl | input | 4 | Interlaced encoder select code |
| sel_tx | input | 4 | Transmitter pixel port select code |
| cons_gate | input | 3 | Consumer gates: bit 0 progressive, 1 interlaced, 2 transmitter |
| alt_tick | input | 1 | /1 pulse of the alternate channel |
| tap_ce | output | 5 | Gated tap pulses |
| prog_ce | output | 1 | Progressive encoder clock enable |
| intl_ce | output | 1 | Interlaced encoder clock enable |
| tx_ce | output | 1 | Transmitter pixel clock enable |

## Verification
The bench measures pulse spacing on each consumer for every tap code, the alternate code and several divide values including N=1 and N=55; a tap counting fast cycles instead of main pulses, or a /6 and /12 built as power-of-two dividers, shows the wrong gap. A divide value changed in mid-period must let the running period finish at the old length, so a design that reloads at once produces a short gap. Reserved codes and gated taps must stay silent, which catches a decoder that folds code 5 onto a real tap, and after a soft reset the first pulse must come exactly N cycles later, which catches a chain that keeps stale sub-counter phase.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
  localparam int unsigned NUM_TAPS = 5;
  localparam int unsigned NUM_CONS = 3;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned ALT_CODE = 8;

  // Division ratio of tap k relative to the main divided rate.
  function automatic int unsigned tap_ratio(input int unsigned k);
    case (k)
      0:       return 1;
      1:       return 2;
      2:       return 4;
      3:       return 6;
      default: return 12;
    endcase
  endfunction

  // Select-code decode: tap index, alternate channel, or nothing.
  function automatic logic pick_tap(input logic [SEL_W-1:0] sel,
                                    input logic [NUM_TAPS-1:0] taps,
                                    input logic alt);
    logic r;
    r = 1'b0;
    if (sel == SEL_W'(ALT_CODE)) r = alt;
    else begin
      for (int k = 0; k < int'(NUM_TAPS); k++)
        if (sel == SEL_W'(k)) r = taps[k];
    end
    return r;
  endfunction
endpackage

// File: rtl/vclk_main_div.sv
module vclk_main_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] lim_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim_q;

  assign tick  = run && (cnt_q == lim_q);
  assign cnt_o = cnt_q;
  assign lim_o = lim_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
      lim_q <= div_val;
    end else if (tick) begin
      cnt_q <= '0;
      lim_q <= div_val;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/vclk_tap_ctr.sv
module vclk_tap_ctr #(
  parameter int unsigned RATIO = 2,
  parameter int unsigned SUB_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic main_tick,
  output logic tap_raw
);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(RATIO - 1);
  logic [SUB_W-1:0] sub_q;

  assign tap_raw = main_tick && (sub_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sub_q <= '0;
    else if (!run)       sub_q <= '0;
    else if (main_tick)  sub_q <= (sub_q == LAST) ? '0 : sub_q + 1'b1;
  end
endmodule

// File: rtl/vclk_cons_sel.sv
module vclk_cons_sel
  import vclk_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    sel,
  input  logic                gate,
  input  logic [NUM_TAPS-1:0] taps,
  input  logic                alt,
  output logic                ce
);
  logic picked;
  assign picked = pick_tap(sel, taps, alt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce <= 1'b0;
    else        ce <= gate && picked;
  end
endmodule

// File: rtl/vclk_tap_divider.sv
module vclk_tap_divider
  import vclk_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    div_val,
  input  logic                div_en,
  input  logic                div_rst,
  input  logic                soft_rst,
  input  logic                chan_en,
  input  logic [4:0]          tap_gate,
  input  logic [3:0]          sel_prog,
  input  logic [3:0]          sel_intl,
  input  logic [3:0]          sel_tx,
  input  logic [2:0]          cons_gate,
  input  logic                alt_tick,
  output logic [4:0]          tap_ce,
  output logic                prog_ce,
  output logic                intl_ce,
  output logic                tx_ce
);
  localparam int unsigned MAX_RATIO = tap_ratio(NUM_TAPS - 1);
  localparam int unsigned SUB_W     = $clog2(MAX_RATIO);

  // Internal events, named for the checker.
  logic             run;
  logic             main_tick;
  logic [DIV_W-1:0] main_cnt;
  logic [DIV_W-1:0] main_lim;
  logic [NUM_TAPS-1:0] tap_raw;
  logic [SEL_W-1:0] sel_arr [NUM_CONS];
  logic [NUM_CONS-1:0] ce_arr;

  assign run = div_en && !div_rst && !soft_rst;

  vclk_main_div #(.DIV_W(DIV_W)) u_main (
    .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_val),
    .tick(main_tick), .cnt_o(main_cnt), .lim_o(main_lim)
  );

  for (genvar k = 0; k < int'(NUM_TAPS); k++) begin : g_tap
    vclk_tap_ctr #(.RATIO(tap_ratio(k)), .SUB_W(SUB_W)) u_tap (
      .clk(clk), .rst_n(rst_n), .run(run),
      .main_tick(main_tick), .tap_raw(tap_raw[k])
    );
  end

  assign tap_ce = tap_raw & tap_gate & {NUM_TAPS{chan_en}};

  assign sel_arr[0] = sel_prog;
  assign sel_arr[1] = sel_intl;
  assign sel_arr[2] = sel_tx;

  for (genvar c = 0; c < int'(NUM_CONS); c++) begin : g_cons
    vclk_cons_sel u_sel (
      .clk(clk), .rst_n(rst_n), .sel(sel_arr[c]), .gate(cons_gate[c]),
      .taps(tap_ce), .alt(alt_tick), .ce(ce_arr[c])
    );
  end

  assign prog_ce = ce_arr[0];
  assign intl_ce = ce_arr[1];
  assign tx_ce   = ce_arr[2];
endmodule

// File: rtl/vclk_tap_checker.sv
module vclk_tap_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       div_en,
  input logic       div_rst,
  input logic       soft_rst,
  input logic       chan_en,
  input logic [3:0] sel_prog,
  input logic [2:0] cons_gate,
  input logic [4:0] tap_ce,
  input logic       prog_ce,
  input logic       intl_ce,
  input logic       tx_ce,
  input logic       main_tick,
  input logic [7:0] main_cnt,
  input logic [7:0] main_lim
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    main_cnt <= main_lim); // R1
  AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_en || div_rst) |-> !main_tick); // R2
  AST_TAP_ON_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (|tap_ce) |-> main_tick); // R3
  AST_TAP2_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tap_ce[1] |=> !tap_ce[1]); // R3
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_prog > 4'd4 && sel_prog != 4'd8) |=> !prog_ce); // R6
  AST_PROG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_gate[0] |=> !prog_ce); // R7
  AST_INTL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_gate[1] |=> !intl_ce); // R7
  AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cons_gate[2] |=> !tx_ce); // R7
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> (tap_ce == 5'd0)); // R7
  AST_SOFT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> !main_tick); // R9
endmodule

bind vclk_tap_divider vclk_tap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .div_en(div_en), .div_rst(div_rst),
  .soft_rst(soft_rst), .chan_en(chan_en), .sel_prog(sel_prog),
  .cons_gate(cons_gate), .tap_ce(tap_ce), .prog_ce(prog_ce),
  .intl_ce(intl_ce), .tx_ce(tx_ce), .main_tick(main_tick),
  .main_cnt(main_cnt), .main_lim(main_lim)
);

// File: tb/tb_vclk_tap_divider.sv
`timescale 1ns/1ps
module tb_vclk_tap_divider;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] div_val = 8'd3;
  logic div_en = 1'b0, div_rst = 1'b1, soft_rst = 1'b0, chan_en = 1'b0;
  logic [4:0] tap_gate = 5'h00;
  logic [3:0] sel_prog = 4'd0, sel_intl = 4'd0, sel_tx = 4'd0;
  logic [2:0] cons_gate = 3'b000;
  logic alt_tick = 1'b0;
  logic [4:0] tap_ce;
  logic prog_ce, intl_ce, tx_ce;

  always #2.5 clk = ~clk;

  vclk_tap_divider dut (.*);

  int total = 0, bad = 0, cyc = 0, altc = 0;
  int ratio [5] = '{1, 2, 4, 6, 12};
  int m_cnt = 0, m_lim = 0;
  int sub [5] = '{0, 0, 0, 0, 0};
  logic [2:0] exp_cons = 3'b000;
  int last [3] = '{0, 0, 0};
  int gap [3] = '{0, 0, 0};
  int npulse [3] = '{0, 0, 0};

  function automatic logic [4:0] model_taps();
    logic [4:0] t;
    bit run, tick;
    run  = div_en && !div_rst && !soft_rst;
    tick = run && (m_cnt == m_lim);
    for (int k = 0; k < 5; k++)
      t[k] = tick && (sub[k] == ratio[k] - 1) && tap_gate[k] && chan_en;
    return t;
  endfunction

  function automatic logic model_pick(logic [3:0] s, logic [4:0] t);
    if (s == 4'd8) return alt_tick;
    if (s <= 4'd4) return t[s];
    return 1'b0;
  endfunction

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lim = 0; exp_cons = 3'b000;
      for (int k = 0; k < 5; k++) sub[k] = 0;
    end else begin
      logic [4:0] t;
      bit run, tick;
      t = model_taps();
      exp_cons[0] = cons_gate[0] && model_pick(sel_prog, t);
      exp_cons[1] = cons_gate[1] && model_pick(sel_intl, t);
      exp_cons[2] = cons_gate[2] && model_pick(sel_tx, t);
      run  = div_en && !div_rst && !soft_rst;
      tick = run && (m_cnt == m_lim);
      if (!run) begin
        m_cnt = 0; m_lim = div_val;
        for (int k = 0; k < 5; k++) sub[k] = 0;
      end else if (tick) begin
        m_cnt = 0; m_lim = div_val;
        for (int k = 0; k < 5; k++) sub[k] = (sub[k] == ratio[k] - 1) ? 0 : sub[k] + 1;
      end else m_cnt++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // One cycle: wait for the falling edge, compare, then move the alternate source.
  task automatic step();
    logic [2:0] o;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (rst_n) begin
      chk(tap_ce == model_taps(), "R3 tap_ce", int'(tap_ce), int'(model_taps()));
      o = {tx_ce, intl_ce, prog_ce};
      chk(o == exp_cons, "R4 consumer outputs", int'(o), int'(exp_cons));
      for (int i = 0; i < 3; i++)
        if (o[i]) begin gap[i] = cyc - last[i]; last[i] = cyc; npulse[i]++; end
    end
    alt_tick = (altc == 4);
    altc = (altc + 1) % 5;
  endtask

  function automatic logic cons_out(int i);
    return (i == 0) ? prog_ce : (i == 1) ? intl_ce : tx_ce;
  endfunction

  task automatic expect_gap(int i, int exp, string req);
    int n = 0;
    npulse[i] = 0;
    while (npulse[i] < 3 && n < 3000) begin step(); n++; end
    chk(npulse[i] >= 3 && gap[i] == exp, req, gap[i], exp);
  endtask

  task automatic expect_none(int i, int cycles, string req);
    int seen = 0;
    for (int n = 0; n < cycles; n++) begin step(); if (cons_out(i)) seen++; end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic wait_pulse(int i);
    int n = 0;
    do begin step(); n++; end while (!cons_out(i) && n < 3000);
  endtask

  initial begin
    int t0, k;
    repeat (3) step();
    chk({tap_ce, prog_ce, intl_ce, tx_ce} == 8'd0, "R2 reset state", int'({tap_ce, prog_ce, intl_ce, tx_ce}), 0);
    rst_n = 1'b1;
    chan_en = 1'b1; tap_gate = 5'h1f; cons_gate = 3'b111;
    expect_none(0, 40, "R2 held by div_rst");
    div_rst = 1'b0;
    expect_none(0, 40, "R2 held by cleared div_en");
    div_en = 1'b1; div_val = 8'd3;
    sel_prog = 4'd0; sel_intl = 4'd1; sel_tx = 4'd2;
    expect_gap(0, 4, "R1 /1 N=4");
    expect_gap(1, 8, "R4 code1 /2");
    expect_gap(2, 16, "R4 code2 /4");
    sel_prog = 4'd3; sel_intl = 4'd4;
    expect_gap(0, 24, "R3 code3 /6");
    expect_gap(1, 48, "R3 code4 /12");
    sel_tx = 4'd8;
    expect_gap(2, 5, "R5 alternate channel");
    div_val = 8'd54; sel_prog = 4'd0;
    expect_gap(0, 55, "R1 N=55");
    div_val = 8'd0; sel_intl = 4'd1;
    expect_gap(0, 1, "R1 N=1");
    expect_gap(1, 2, "R4 /2 at N=1");
    div_val = 8'd2; sel_prog = 4'd3;
    expect_gap(0, 18, "R3 /6 at N=3");
    sel_prog = 4'd5;
    expect_none(0, 80, "R6 reserved code 5");
    sel_prog = 4'd15;
    expect_none(0, 80, "R6 reserved code 15");
    sel_prog = 4'd2; tap_gate = 5'b11011;
    expect_none(0, 80, "R6 selected tap gated");
    tap_gate = 5'h1f; cons_gate = 3'b110;
    expect_none(0, 80, "R7 consumer gate off");
    cons_gate = 3'b111; chan_en = 1'b0;
    expect_none(0, 80, "R7 master enable off");
    chan_en = 1'b1;
    sel_prog = 4'd0; div_val = 8'd9;
    wait_pulse(0); wait_pulse(0);
    t0 = cyc;
    repeat (3) step();
    div_val = 8'd2;
    wait_pulse(0);
    chk(cyc - t0 == 10, "R8 old period finishes", cyc - t0, 10);
    t0 = cyc;
    wait_pulse(0);
    chk(cyc - t0 == 3, "R8 new period applies", cyc - t0, 3);
    div_val = 8'd3; sel_intl = 4'd4;
    repeat (30) step();
    soft_rst = 1'b1;
    expect_none(0, 20, "R9 soft reset holds");
    soft_rst = 1'b0;
    k = 0;
    do begin step(); k++; end while (!prog_ce && k < 200);
    chk(k == 4, "R9 first pulse after restart", k, 4);
    expect_gap(1, 48, "R9 /12 phase after restart");
    div_rst = 1'b1; repeat (2) step(); div_rst = 1'b0;
    k = 0;
    do begin step(); k++; end while (!prog_ce && k < 200);
    chk(k == 4, "R2 first pulse after release", k, 4);
    repeat (200) step();
    finish_run();
  end
endmodule